// File: doc/BRIEF.md
# Paged Read With Counter Streamer

This block answers a read-memory-with-counter request arriving as a byte stream. The first byte must be the command code 0xA5. Two address bytes follow, low byte first. From that start address the block streams memory bytes up to the last byte of the 32-byte page. It then appends a 10-byte page trailer:

- the page's 32-bit count,
- four zero bytes,
- an inverted CRC16.

It then moves on to the next page, starting at offset 0, and repeats this up to the last page. After that it sends 0xFF until the sequence is aborted.

The block also holds four 32-bit event counters, one for each of the four top pages. On the default 16-page memory these are pages 12 to 15:

- Pages 12 and 13 count copy completions reported for those pages.
- Pages 14 and 15 count debounced falling events on two active-low trigger pins, A and B.

Both byte interfaces are valid/ready:

- A byte moves on a clock edge where valid and ready are both high.
- While the block holds `out_valid` high and `out_ready` is low, `out_data` must stay unchanged.
- `in_ready` is high only while the block is waiting for the command or an address byte. It is never high at the same time as `out_valid`.

Memory is read through a combinational address/data port.

Top module: `rdctr_stream`

## Requirements
- R1: While idle, an input byte other than 0xA5 is discarded: `out_valid` stays low and `in_ready` stays high.
- R2: The first address byte supplies address bits 7:0 and the second supplies bits 15:8. Bits above bit 8 are ignored on the default 512-byte memory. Data is streamed from the start address up to offset 31 of its page.
- R3: After each page's data, the trailer is sent in this order:
  - four count bytes, least significant byte first;
  - four 0x00 bytes;
  - the bitwise-inverted CRC16, low byte first.
- R4: On pages 0 to 11, the four count bytes of the trailer read 0xFF.
- R5: The CRC uses polynomial x^16+x^15+x^2+1 and processes each byte LSB first (reflected constant 0xA001). On the first page it starts at 0 and covers the command byte, both address bytes as received, the page data, the count bytes and the zero bytes.
- R6: Each later page starts at offset 0, and its CRC restarts at 0 and covers only that page's data, count bytes and zero bytes.
- R7: After the trailer of page 15, every output byte is 0xFF until `seq_abort`.
- R8: `seq_abort` at any point returns the block to idle on the next cycle: `in_ready` high, `out_valid` low.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `in_ready` and `out_valid` are never high together.
- R10: A trigger pin counts one event after it has been low for DEB_CYCLES consecutive clocks, measured after a 2-flop synchronizer. A shorter low pulse counts nothing. A long low period counts once, and the pin must return high before it can count again.
- R11: Trigger A increments the page-14 count and trigger B increments the page-15 count.
- R12: A `copy_done` pulse increments the page-12 or page-13 count when `copy_page` is 12 or 13. A pulse naming any other page changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears counts and state |
| seq_abort | input | 1 | Ends the current sequence, back to idle |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Ready for a command or address byte |
| in_data | input | 8 | Command or address byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Streamed data, trailer or fill byte |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, combinational |
| copy_done | input | 1 | One-cycle pulse: a copy into `copy_page` finished |
| copy_page | input | ADDR_W-5 | Page number of the finished copy |
| trig_a_n | input | 1 | Active-low trigger A (page-14 count) |
| trig_b_n | input | 1 | Active-low trigger B (page-15 count) |

## Verification
The assertions check the following on every cycle:

- the output byte is held under back-pressure;
- the read address steps by exactly one inside a page;
- the block is idle on the cycle after an abort;
- no count ever moves by more than one per clock;
- a debounced event is never reported on two cycles in a row.

The content of the stream can only be shown by the bench's scenarios:

- the data bytes;
- the trailer layout;
- the FF count field on pages without a counter;
- the first-page and later-page CRC seeding;
- the fill after the last page.

The same holds for the exact debounce threshold and for the routing of triggers and copies to the right counter. The bench computes all of these arithmetically, sweeping every start offset of one page.

// File: rtl/rdctr_pkg.sv
package rdctr_pkg;

  localparam logic [7:0] CMD_RD_CTR = 8'hA5;
  localparam int         TRAIL_LEN  = 10;
  localparam int         CTR_W      = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TA_LO, ST_TA_HI, ST_DATA, ST_TRAIL, ST_ONES
  } st_t;

  // one byte into a reflected CRC16 (0xA001), LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  b);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

endpackage

// File: rtl/rdctr_debounce.sv
module rdctr_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  output logic evt
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] low_cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      low_cnt <= '0;
      armed   <= 1'b1;
      evt     <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], trig_n};
      evt    <= 1'b0;
      if (sync_q[1]) begin
        low_cnt <= '0;
        armed   <= 1'b1;
      end else if (armed) begin
        if (low_cnt == CW'(DEB_CYCLES - 1)) begin
          evt     <= 1'b1;
          armed   <= 1'b0;
          low_cnt <= '0;
        end else begin
          low_cnt <= low_cnt + 1'b1;
        end
      end
    end
  end

  // R10
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/rdctr_counters.sv
module rdctr_counters
  import rdctr_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter int CTR_BASE = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       copy_done,
  input  logic [PAGE_W-1:0]          copy_page,
  input  logic                       evt_a,
  input  logic                       evt_b,
  output logic [3:0][CTR_W-1:0]      ctrs
);

  for (genvar i = 0; i < 4; i++) begin : g_ctr
    logic inc;
    if (i < 2) begin : g_copy
      assign inc = copy_done && (copy_page == PAGE_W'(CTR_BASE + i));
    end else if (i == 2) begin : g_trig_a
      assign inc = evt_a;
    end else begin : g_trig_b
      assign inc = evt_b;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   ctrs[i] <= '0;
      else if (inc) ctrs[i] <= ctrs[i] + 1'b1;
    end

    // R11 R12
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrs[i] != $past(ctrs[i])) |-> (ctrs[i] == CTR_W'($past(ctrs[i]) + 1'b1)));
  end

endmodule

// File: rtl/rdctr_stream.sv
module rdctr_stream
  import rdctr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DEB_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seq_abort,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [7:0]             mem_rdata,
  input  logic                   copy_done,
  input  logic [ADDR_W-6:0]      copy_page,
  input  logic                   trig_a_n,
  input  logic                   trig_b_n
);
  localparam int OFS_W     = 5;
  localparam int PAGE_W    = ADDR_W - OFS_W;
  localparam int NUM_PAGES = 1 << PAGE_W;
  localparam int CTR_BASE  = NUM_PAGES - 4;

  st_t                    st_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [7:0]             ta_lo_q;
  logic [3:0]             idx_q;
  logic [15:0]            crc_q;
  logic [CTR_W-1:0]       snap_q;
  logic [3:0][CTR_W-1:0]  ctrs;
  logic                   evt_a, evt_b;
  logic [PAGE_W-1:0]      page;
  logic                   has_ctr, in_fire, out_fire;

  rdctr_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb_a (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_a_n), .evt(evt_a));
  rdctr_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb_b (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_b_n), .evt(evt_b));

  rdctr_counters #(.PAGE_W(PAGE_W), .CTR_BASE(CTR_BASE)) u_ctrs (
    .clk(clk), .rst_n(rst_n), .copy_done(copy_done), .copy_page(copy_page),
    .evt_a(evt_a), .evt_b(evt_b), .ctrs(ctrs));

  assign page      = addr_q[ADDR_W-1:OFS_W];
  assign has_ctr   = page >= PAGE_W'(CTR_BASE);
  assign mem_addr  = addr_q;
  assign in_ready  = (st_q == ST_IDLE) || (st_q == ST_TA_LO) || (st_q == ST_TA_HI);
  assign out_valid = (st_q == ST_DATA) || (st_q == ST_TRAIL) || (st_q == ST_ONES);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;

  always_comb begin
    out_data = 8'hFF;
    case (st_q)
      ST_DATA:  out_data = mem_rdata;
      ST_TRAIL: begin
        if (idx_q < 4'd4)       out_data = snap_q[idx_q[1:0]*8 +: 8];
        else if (idx_q < 4'd8)  out_data = 8'h00;
        else if (idx_q == 4'd8) out_data = ~crc_q[7:0];
        else                    out_data = ~crc_q[15:8];
      end
      default:  out_data = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      ta_lo_q <= '0;
      idx_q   <= '0;
      crc_q   <= '0;
      snap_q  <= '0;
    end else if (seq_abort) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (in_fire && in_data == CMD_RD_CTR) begin
          crc_q <= crc16_byte(16'h0000, in_data);
          st_q  <= ST_TA_LO;
        end
        ST_TA_LO: if (in_fire) begin
          ta_lo_q <= in_data;
          crc_q   <= crc16_byte(crc_q, in_data);
          st_q    <= ST_TA_HI;
        end
        ST_TA_HI: if (in_fire) begin
          addr_q <= ADDR_W'({in_data, ta_lo_q});
          crc_q  <= crc16_byte(crc_q, in_data);
          st_q   <= ST_DATA;
        end
        ST_DATA: if (out_fire) begin
          crc_q <= crc16_byte(crc_q, mem_rdata);
          if (addr_q[OFS_W-1:0] == '1) begin
            st_q   <= ST_TRAIL;
            idx_q  <= '0;
            snap_q <= has_ctr ? ctrs[page[1:0]] : '1;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_TRAIL: if (out_fire) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q < 4'd8) crc_q <= crc16_byte(crc_q, out_data);
          if (idx_q == 4'(TRAIL_LEN - 1)) begin
            if (page == '1) begin
              st_q <= ST_ONES;
            end else begin
              addr_q <= addr_q + 1'b1;
              crc_q  <= '0;
              st_q   <= ST_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !seq_abort) |=> (out_valid && $stable(out_data)));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (in_ready && !out_valid));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && out_fire && !seq_abort && mem_addr[OFS_W-1:0] != '1)
      |=> (mem_addr == $past(mem_addr) + 1'b1));

endmodule

// File: tb/rdctr_stream_tb.sv
`timescale 1ns/1ps
module rdctr_stream_tb;
  localparam int ADDR_W = 9;
  localparam int DEB    = 5;

  logic clk = 0, rst_n = 0, seq_abort = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0] in_data = 0, out_data, mem_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic copy_done = 0;
  logic [3:0] copy_page = 0;
  logic trig_a_n = 1, trig_b_n = 1;

  int nchk = 0, nfail = 0, nrx = 0;
  bit stall_on = 0;
  int ctr_exp [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  function automatic int memf(int a);
    return (a * 37 + 11) & 'hFF;
  endfunction
  assign mem_rdata = 8'(memf(int'(mem_addr)));

  rdctr_stream #(.ADDR_W(ADDR_W), .DEB_CYCLES(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_abort(seq_abort),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .copy_done(copy_done), .copy_page(copy_page),
    .trig_a_n(trig_a_n), .trig_b_n(trig_b_n));

  function automatic int crc_b(int c, int b);
    c = c ^ b;
    for (int k = 0; k < 8; k++) c = (c & 1) ? ((c >> 1) ^ 'hA001) : (c >> 1);
    return c & 'hFFFF;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(int v);
    in_valid = 1; in_data = 8'(v);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic recv(int exp, string req);
    logic [7:0] v0;
    if (stall_on && (nrx % 7 == 3)) begin
      out_ready = 0; v0 = out_data;
      @(negedge clk); @(negedge clk);
      chk(out_valid && out_data == v0, "R9 stall hold", out_data, v0);
    end
    out_ready = 1;
    chk(out_valid && out_data == 8'(exp), req, out_data, exp);
    @(negedge clk);
    out_ready = 0;
    nrx++;
  endtask

  task automatic abort_seq();
    seq_abort = 1; @(negedge clk); seq_abort = 0;
    chk(in_ready && !out_valid, "R8 idle after abort", {in_ready, out_valid}, 2);
  endtask

  // issue a read at ta; stop after max_pages trailers or max_bytes bytes
  task automatic do_read(int ta, int max_pages, int max_bytes, int ones_n);
    int a, c, p, cv, left, pages;
    string crq;
    send_byte('hA5); send_byte(ta & 'hFF); send_byte((ta >> 8) & 'hFF);
    a = ta & 'h1FF;
    c = crc_b(crc_b(crc_b(0, 'hA5), ta & 'hFF), (ta >> 8) & 'hFF);
    left = max_bytes; pages = 0; crq = "R5 first-page crc";
    while (left > 0) begin
      p = a >> 5;
      while (left > 0) begin
        recv(memf(a), "R2 data"); left--; c = crc_b(c, memf(a));
        if ((a & 31) == 31) break;
        a++;
      end
      if (left == 0) break;
      cv = (p >= 12) ? ctr_exp[p - 12] : 'hFFFFFFFF;
      for (int k = 0; k < 4; k++) begin
        recv((cv >> (8 * k)) & 'hFF, (p >= 12) ? "R3 count field" : "R4 no-counter FF");
        c = crc_b(c, (cv >> (8 * k)) & 'hFF);
      end
      for (int k = 0; k < 4; k++) begin recv(0, "R3 zero pad"); c = crc_b(c, 0); end
      recv((~c) & 'hFF, crq);
      recv(((~c) >> 8) & 'hFF, crq);
      left -= 10; pages++;
      crq = "R6 later-page crc";
      if (p == 15) begin
        for (int k = 0; k < ones_n; k++) recv('hFF, "R7 fill ones");
        break;
      end
      if (pages == max_pages) break;
      a++; c = 0;
    end
    abort_seq();
  endtask

  task automatic copy_evt(int pg);
    copy_done = 1; copy_page = 4'(pg);
    @(negedge clk);
    copy_done = 0;
    if (pg == 12 || pg == 13) ctr_exp[pg - 12]++;
  endtask

  task automatic trig(bit which_b, int n);
    if (which_b) trig_b_n = 0; else trig_a_n = 0;
    repeat (n) @(negedge clk);
    trig_a_n = 1; trig_b_n = 1;
    repeat (DEB + 6) @(negedge clk);
    if (n >= DEB) ctr_exp[which_b ? 3 : 2]++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R9 reset state", {in_ready, out_valid}, 2);

    // R1: foreign command byte is dropped
    send_byte('hF0);
    chk(!out_valid && in_ready, "R1 foreign cmd ignored", {in_ready, out_valid}, 2);
    send_byte('h0F);
    chk(!out_valid && in_ready, "R1 foreign cmd ignored", {in_ready, out_valid}, 2);

    // R12: copies, including pages without a copy counter
    repeat (3) copy_evt(12);
    copy_evt(13);
    copy_evt(5);
    copy_evt(14);
    copy_evt(15);

    // R10 R11: debounce boundaries
    trig(0, DEB);        // exact threshold: counts
    trig(0, DEB - 1);    // one short: nothing
    trig(0, 40);         // long low: once
    trig(1, 2);          // short: nothing
    trig(1, DEB + 1);    // counts

    // whole memory from 0 with back-pressure (R2-R7, R9)
    stall_on = 1;
    do_read('h0000, 99, 100000, 4);
    stall_on = 0;

    // last byte of page 14: R10 R11 counts, then page 15 and fill (R7)
    do_read('h01DF, 99, 100000, 3);
    // very last byte of memory
    do_read('h01FF, 99, 100000, 2);

    // sweep every start offset of page 13 with junk high address bits (R2, R12)
    for (int o = 0; o < 32; o++) do_read('hA000 | (13 * 32 + o), 1, 100000, 0);

    // abort mid-data then mid-trailer (R8)
    do_read('h0040, 99, 3, 0);
    do_read('h005E, 99, 5, 0);
    do_read('h0020, 99, 40, 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule